// File: doc/BRIEF.md
# Processor event priority and vectoring unit

This unit sits next to a small CPU pipeline and picks one pending event each time the pipeline must be redirected. Six events can ask for service: reset, hardware exception, non-maskable break, maskable break, interrupt and user exception. The unit applies the enable and in-progress gating, picks the winner by fixed rank, and in the following cycle presents the redirect address, the register that receives the return address together with its write strobe and data, a clear pulse for the exclusive-access reservation flag, and an acknowledge.

Each vector is a parameterised base address, aligned to 0x100, plus a fixed offset. Every vector slot is eight bytes wide, which leaves room for an immediate prefix followed by an absolute branch. When the low-latency interrupt mode is selected, the interrupt redirect address comes from an external controller input and is not computed from the base. All outputs are registered. After a taken event the unit rests for one cycle while the pipeline redirects.

Top module: `evt_vector_unit`

## Requirements
- R1: Among eligible requests the winner is the first in this rank, highest first: reset, hardware exception, non-maskable break, maskable break, interrupt, user exception. `evt_id` encodes the winner as 0 reset, 1 hardware exception, 2 non-maskable break, 3 maskable break, 4 interrupt, 5 user exception, and shows 7 when nothing is taken.
- R2: `vec_addr` equals `BASE_VEC` plus an offset: 0x00 for reset, 0x08 for user exception, 0x10 for interrupt and 0x20 for hardware exception.
- R3: Every vector formed from the base is a multiple of 8 bytes above `BASE_VEC` and never falls in the offsets 0x28 to 0x4F, so the largest offset used is 0x20.
- R4: Both break kinds redirect to `BASE_VEC` + 0x18 and write their return address to register 16.
- R5: An interrupt writes register 14. A hardware exception writes register 17 with `ret_btr`=0. If `hw_exc_in_slot` is set, it writes the branch-target register instead, shown as `ret_btr`=1 and `ret_idx`=0.
- R6: A user exception writes the register named by `user_ret_idx`. A reset raises `ret_we` for no register, so `ret_we`, `ret_idx` and `ret_data` stay 0.
- R7: When `fast_irq_mode`=1, a taken interrupt uses `fast_irq_vec` as `vec_addr` and not base + 0x10.
- R8: `resv_clear` pulses together with `evt_ack` for every taken event, reset included.
- R9: An interrupt is eligible only while `irq_enable`=1, `brk_busy`=0 and `exc_busy`=0.
- R10: A maskable break is blocked while `brk_busy`=1. A non-maskable break is never blocked.
- R11: Outputs change on the clock edge after the request is sampled. `evt_ack`, `vec_valid`, `ret_we` and `resv_clear` last one cycle, and no event is taken in the cycle right after an acknowledge. With no eligible request these outputs are 0, `evt_id` is 7, and `vec_addr`, `ret_idx`, `ret_btr` and `ret_data` are 0.
- R12: `ret_data` carries the `ret_pc` sampled with the taken event whenever `ret_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the unit's registers |
| req_reset | input | 1 | Reset event request |
| req_hw_exc | input | 1 | Hardware exception request |
| req_nm_brk | input | 1 | Non-maskable break request |
| req_brk | input | 1 | Maskable break request (hardware or software) |
| req_irq | input | 1 | Interrupt request |
| req_user | input | 1 | User exception request |
| irq_enable | input | 1 | Interrupt enable |
| brk_busy | input | 1 | A break handler is in progress |
| exc_busy | input | 1 | An exception handler is in progress |
| hw_exc_in_slot | input | 1 | Hardware fault happened in a branch delay slot |
| user_ret_idx | input | 5 | Return register chosen by the user-exception instruction |
| ret_pc | input | 32 | Return address to save |
| fast_irq_mode | input | 1 | Low-latency interrupt mode select |
| fast_irq_vec | input | 32 | Interrupt address from the external controller |
| evt_ack | output | 1 | One-cycle acknowledge of the taken event |
| evt_id | output | 3 | Code of the taken event, 7 when idle |
| vec_valid | output | 1 | `vec_addr` is valid this cycle |
| vec_addr | output | 32 | Redirect address |
| ret_we | output | 1 | Return-register write strobe |
| ret_btr | output | 1 | Write goes to the branch-target register |
| ret_idx | output | 5 | General register index for the return address |
| ret_data | output | 32 | Return address to write |
| resv_clear | output | 1 | Clear pulse for the exclusive-access reservation |

## Verification
If a gating term or a rank position is wrong, the next edge after a request pattern shows a wrong `evt_id`, vector and return register. Random request mixes hit most patterns within a few hundred cycles. A stuck output register or a broken rest cycle appears as an acknowledge held two cycles in a row, or as strobes while idle, and is seen at the first back-to-back request. A wrong offset or return-register mapping shows on the first event of that kind, which the directed cases provoke early with a non-zero base.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int unsigned N_EVT = 6;

    localparam int unsigned I_RESET = 0;
    localparam int unsigned I_HWEXC = 1;
    localparam int unsigned I_NMBRK = 2;
    localparam int unsigned I_BRK   = 3;
    localparam int unsigned I_IRQ   = 4;
    localparam int unsigned I_USER  = 5;

    typedef enum logic [2:0] {
        EV_RESET = 3'd0,
        EV_HWEXC = 3'd1,
        EV_NMBRK = 3'd2,
        EV_BRK   = 3'd3,
        EV_IRQ   = 3'd4,
        EV_USER  = 3'd5,
        EV_NONE  = 3'd7
    } evt_e;

    // Slot offset inside the vector area; every slot spans two words.
    function automatic logic [7:0] evt_offset(input evt_e e);
        case (e)
            EV_USER:          return 8'h08;
            EV_IRQ:           return 8'h10;
            EV_NMBRK, EV_BRK: return 8'h18;
            EV_HWEXC:         return 8'h20;
            default:          return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/evt_gate.sv
module evt_gate
    import evt_pkg::*;
#(
    parameter int unsigned NE = N_EVT
) (
    input  logic [NE-1:0] req_i,
    input  logic          irq_en_i,
    input  logic          brk_busy_i,
    input  logic          exc_busy_i,
    output logic [NE-1:0] elig_o
);

    always_comb begin
        elig_o         = req_i;
        elig_o[I_BRK]  = req_i[I_BRK] & ~brk_busy_i;
        elig_o[I_IRQ]  = req_i[I_IRQ] & irq_en_i & ~brk_busy_i & ~exc_busy_i;
    end

endmodule

// File: rtl/evt_prio.sv
module evt_prio
    import evt_pkg::*;
#(
    parameter int unsigned NE = N_EVT
) (
    input  logic [NE-1:0] elig_i,
    output logic          hit_o,
    output evt_e          sel_o
);

    logic [NE:0]   clear_above;
    logic [NE-1:0] grant;

    assign clear_above[0] = 1'b1;

    for (genvar g = 0; g < NE; g++) begin : g_rank
        assign grant[g]          = elig_i[g] & clear_above[g];
        assign clear_above[g+1]  = clear_above[g] & ~elig_i[g];
    end

    assign hit_o = |grant;

    always_comb begin
        sel_o = EV_NONE;
        for (int i = 0; i < NE; i++) begin
            if (grant[i]) sel_o = evt_e'(3'(i));
        end
    end

endmodule

// File: rtl/evt_target.sv
module evt_target
    import evt_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter logic [AW-1:0] BASE   = '0,
    parameter int unsigned RW       = 5,
    parameter int unsigned IRQ_REG  = 14,
    parameter int unsigned BRK_REG  = 16,
    parameter int unsigned EXC_REG  = 17
) (
    input  evt_e          sel_i,
    input  logic          fast_mode_i,
    input  logic [AW-1:0] fast_vec_i,
    input  logic          in_slot_i,
    input  logic [RW-1:0] user_idx_i,
    output logic [AW-1:0] vec_o,
    output logic          we_o,
    output logic          btr_o,
    output logic [RW-1:0] idx_o
);

    always_comb begin
        vec_o = BASE + AW'(evt_offset(sel_i));
        if (sel_i == EV_IRQ && fast_mode_i) vec_o = fast_vec_i;

        we_o  = (sel_i != EV_RESET) && (sel_i != EV_NONE);
        btr_o = 1'b0;
        idx_o = '0;
        case (sel_i)
            EV_USER:          idx_o = user_idx_i;
            EV_IRQ:           idx_o = RW'(IRQ_REG);
            EV_NMBRK, EV_BRK: idx_o = RW'(BRK_REG);
            EV_HWEXC: begin
                if (in_slot_i) btr_o = 1'b1;
                else           idx_o = RW'(EXC_REG);
            end
            default:          idx_o = '0;
        endcase
    end

endmodule

// File: rtl/evt_vector_unit.sv
module evt_vector_unit
    import evt_pkg::*;
#(
    parameter int unsigned   AW       = 32,
    parameter logic [AW-1:0] BASE_VEC = '0,
    parameter int unsigned   RW       = 5,
    parameter int unsigned   IRQ_REG  = 14,
    parameter int unsigned   BRK_REG  = 16,
    parameter int unsigned   EXC_REG  = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_reset,
    input  logic          req_hw_exc,
    input  logic          req_nm_brk,
    input  logic          req_brk,
    input  logic          req_irq,
    input  logic          req_user,
    input  logic          irq_enable,
    input  logic          brk_busy,
    input  logic          exc_busy,
    input  logic          hw_exc_in_slot,
    input  logic [RW-1:0] user_ret_idx,
    input  logic [AW-1:0] ret_pc,
    input  logic          fast_irq_mode,
    input  logic [AW-1:0] fast_irq_vec,
    output logic          evt_ack,
    output logic [2:0]    evt_id,
    output logic          vec_valid,
    output logic [AW-1:0] vec_addr,
    output logic          ret_we,
    output logic          ret_btr,
    output logic [RW-1:0] ret_idx,
    output logic [AW-1:0] ret_data,
    output logic          resv_clear
);

    localparam int unsigned NE = N_EVT;

    typedef struct packed {
        logic          ack;
        evt_e          id;
        logic          vld;
        logic [AW-1:0] vec;
        logic          we;
        logic          btr;
        logic [RW-1:0] idx;
        logic [AW-1:0] data;
        logic          clr;
    } out_s;

    localparam out_s IDLE = '{ack: 1'b0, id: EV_NONE, vld: 1'b0, vec: '0,
                              we: 1'b0, btr: 1'b0, idx: '0, data: '0, clr: 1'b0};

    out_s o_d, o_q;

    logic [NE-1:0] req_vec, elig;
    logic          hit;
    evt_e          sel;
    logic [AW-1:0] tgt_vec;
    logic          tgt_we, tgt_btr;
    logic [RW-1:0] tgt_idx;

    assign req_vec = {req_user, req_irq, req_brk, req_nm_brk, req_hw_exc, req_reset};

    evt_gate #(.NE(NE)) gate_i (
        .req_i      (req_vec),
        .irq_en_i   (irq_enable),
        .brk_busy_i (brk_busy),
        .exc_busy_i (exc_busy),
        .elig_o     (elig)
    );

    evt_prio #(.NE(NE)) prio_i (
        .elig_i (elig),
        .hit_o  (hit),
        .sel_o  (sel)
    );

    evt_target #(
        .AW(AW), .BASE(BASE_VEC), .RW(RW),
        .IRQ_REG(IRQ_REG), .BRK_REG(BRK_REG), .EXC_REG(EXC_REG)
    ) target_i (
        .sel_i       (sel),
        .fast_mode_i (fast_irq_mode),
        .fast_vec_i  (fast_irq_vec),
        .in_slot_i   (hw_exc_in_slot),
        .user_idx_i  (user_ret_idx),
        .vec_o       (tgt_vec),
        .we_o        (tgt_we),
        .btr_o       (tgt_btr),
        .idx_o       (tgt_idx)
    );

    // Take at most one event, then rest one cycle while the pipeline redirects.
    always_comb begin
        o_d = IDLE;
        if (hit && !o_q.ack) begin
            o_d.ack  = 1'b1;
            o_d.id   = sel;
            o_d.vld  = 1'b1;
            o_d.vec  = tgt_vec;
            o_d.we   = tgt_we;
            o_d.btr  = tgt_btr;
            o_d.idx  = tgt_idx;
            o_d.data = tgt_we ? ret_pc : '0;
            o_d.clr  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= IDLE;
        else        o_q <= o_d;
    end

    assign evt_ack    = o_q.ack;
    assign evt_id     = o_q.id;
    assign vec_valid  = o_q.vld;
    assign vec_addr   = o_q.vec;
    assign ret_we     = o_q.we;
    assign ret_btr    = o_q.btr;
    assign ret_idx    = o_q.idx;
    assign ret_data   = o_q.data;
    assign resv_clear = o_q.clr;

endmodule

// File: rtl/evt_vector_unit_chk.sv
module evt_vector_unit_chk
    import evt_pkg::*;
#(
    parameter int unsigned   AW       = 32,
    parameter logic [AW-1:0] BASE_VEC = '0,
    parameter int unsigned   RW       = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_reset,
    input logic          req_hw_exc,
    input logic          req_nm_brk,
    input logic          irq_enable,
    input logic          brk_busy,
    input logic          exc_busy,
    input logic          fast_irq_mode,
    input logic          evt_ack,
    input logic [2:0]    evt_id,
    input logic          vec_valid,
    input logic [AW-1:0] vec_addr,
    input logic          ret_we,
    input logic          resv_clear
);

    logic [AW-1:0] vec_off;
    assign vec_off = vec_addr - BASE_VEC;

    a_r1_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack && evt_id != EV_RESET) |-> !$past(req_reset));

    a_r1_hwexc_second: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack && evt_id != EV_RESET && evt_id != EV_HWEXC) |-> !$past(req_hw_exc));

    a_r10_nm_brk_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack && (evt_id == EV_BRK || evt_id == EV_IRQ || evt_id == EV_USER))
        |-> !$past(req_nm_brk));

    a_r10_brk_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack && evt_id == EV_BRK) |-> !$past(brk_busy));

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack && evt_id == EV_IRQ)
        |-> ($past(irq_enable) && !$past(brk_busy) && !$past(exc_busy)));

    a_r3_vec_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !(evt_id == EV_IRQ && $past(fast_irq_mode)))
        |-> (vec_off[2:0] == 3'b000 && vec_off <= AW'(32'h20)));

    a_r6_reset_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack && evt_id == EV_RESET) |-> !ret_we);

    a_r8_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ack |-> (resv_clear && vec_valid));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ack |=> !evt_ack);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_ack |-> (!ret_we && !vec_valid && !resv_clear && evt_id == EV_NONE));

endmodule

bind evt_vector_unit evt_vector_unit_chk #(
    .AW(AW), .BASE_VEC(BASE_VEC), .RW(RW)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_reset     (req_reset),
    .req_hw_exc    (req_hw_exc),
    .req_nm_brk    (req_nm_brk),
    .irq_enable    (irq_enable),
    .brk_busy      (brk_busy),
    .exc_busy      (exc_busy),
    .fast_irq_mode (fast_irq_mode),
    .evt_ack       (evt_ack),
    .evt_id        (evt_id),
    .vec_valid     (vec_valid),
    .vec_addr      (vec_addr),
    .ret_we        (ret_we),
    .resv_clear    (resv_clear)
);

// File: tb/evt_vector_unit_tb_top.sv
module evt_vector_unit_tb_top;

    localparam int unsigned AW = 32;
    localparam int unsigned RW = 5;
    localparam logic [AW-1:0] TB_BASE = 32'h0000_4300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_reset = 0, req_hw_exc = 0, req_nm_brk = 0, req_brk = 0;
    logic          req_irq = 0, req_user = 0;
    logic          irq_enable = 0, brk_busy = 0, exc_busy = 0, hw_exc_in_slot = 0;
    logic [RW-1:0] user_ret_idx = '0;
    logic [AW-1:0] ret_pc = '0;
    logic          fast_irq_mode = 0;
    logic [AW-1:0] fast_irq_vec = '0;
    logic          evt_ack, vec_valid, ret_we, ret_btr, resv_clear;
    logic [2:0]    evt_id;
    logic [AW-1:0] vec_addr, ret_data;
    logic [RW-1:0] ret_idx;

    always #10 clk = ~clk;

    evt_vector_unit #(.AW(AW), .BASE_VEC(TB_BASE), .RW(RW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_reset(req_reset), .req_hw_exc(req_hw_exc), .req_nm_brk(req_nm_brk),
        .req_brk(req_brk), .req_irq(req_irq), .req_user(req_user),
        .irq_enable(irq_enable), .brk_busy(brk_busy), .exc_busy(exc_busy),
        .hw_exc_in_slot(hw_exc_in_slot), .user_ret_idx(user_ret_idx), .ret_pc(ret_pc),
        .fast_irq_mode(fast_irq_mode), .fast_irq_vec(fast_irq_vec),
        .evt_ack(evt_ack), .evt_id(evt_id), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .ret_we(ret_we), .ret_btr(ret_btr), .ret_idx(ret_idx), .ret_data(ret_data),
        .resv_clear(resv_clear)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // Expected outputs for the next sampling point
    logic          e_ack = 0;
    int            e_id = 7;
    logic [AW-1:0] e_vec = '0, e_data = '0;
    logic          e_we = 0, e_btr = 0;
    logic [RW-1:0] e_idx = '0;
    logic          e_fast = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Winner by rank with gating, straight from the requirements (R1, R9, R10).
    function automatic int pick_event();
        if (req_reset)                                         return 0;
        if (req_hw_exc)                                        return 1;
        if (req_nm_brk)                                        return 2;
        if (req_brk && !brk_busy)                              return 3;
        if (req_irq && irq_enable && !brk_busy && !exc_busy)   return 4;
        if (req_user)                                          return 5;
        return 7;
    endfunction

    function automatic logic [AW-1:0] slot_off(input int id);
        case (id)
            5:       return 32'h08;
            4:       return 32'h10;
            2, 3:    return 32'h18;
            1:       return 32'h20;
            default: return 32'h00;
        endcase
    endfunction

    // Compute expectations from the inputs now applied (called at a falling edge).
    task automatic predict();
        int id;
        id = e_ack ? 7 : pick_event();
        e_fast = fast_irq_mode;
        e_ack = (id != 7);
        e_id  = id;
        e_vec = '0; e_we = 0; e_btr = 0; e_idx = '0; e_data = '0;
        if (id != 7) begin
            e_vec = (id == 4 && fast_irq_mode) ? fast_irq_vec : TB_BASE + slot_off(id);
            e_we  = (id != 0);
            case (id)
                1: if (hw_exc_in_slot) e_btr = 1; else e_idx = 5'd17;
                2, 3: e_idx = 5'd16;
                4: e_idx = 5'd14;
                5: e_idx = user_ret_idx;
                default: e_idx = '0;
            endcase
            if (e_we) e_data = ret_pc;
        end
    endtask

    function automatic string vec_tag();
        if (e_id == 4 && e_fast) return "R7 vec";
        if (e_id == 2 || e_id == 3) return "R4 vec";
        if (e_id == 7) return "R11 vec";
        return "R2 vec";
    endfunction

    function automatic string ret_tag();
        case (e_id)
            1, 4:    return "R5 ret";
            2, 3:    return "R4 ret";
            0, 5:    return "R6 ret";
            default: return "R11 ret";
        endcase
    endfunction

    task automatic compare();
        logic [AW-1:0] off;
        chk("R11 ack", 64'(evt_ack), 64'(e_ack));
        chk("R1 evt_id", 64'(evt_id), 64'(e_id));
        chk("R8 resv_clear", 64'(resv_clear), 64'(e_ack));
        chk("R11 vec_valid", 64'(vec_valid), 64'(e_ack));
        chk(vec_tag(), 64'(vec_addr), 64'(e_vec));
        chk(ret_tag(), 64'(ret_we), 64'(e_we));
        chk(ret_tag(), 64'(ret_idx), 64'(e_idx));
        chk("R5 btr", 64'(ret_btr), 64'(e_btr));
        chk("R12 ret_data", 64'(ret_data), 64'(e_data));
        if (e_ack && !(e_id == 4 && e_fast)) begin
            off = vec_addr - TB_BASE;
            chk("R3 slot", 64'((off[2:0] == 3'b000) && (off <= 32'h20)), 64'd1);
        end
    endtask

    // Apply inputs at a falling edge, then compare one clock later.
    task automatic step(input logic [5:0] req, input logic ien, input logic bb,
                        input logic eb, input logic slot, input logic fm,
                        input logic [RW-1:0] uidx, input logic [AW-1:0] pc,
                        input logic [AW-1:0] fv);
        {req_user, req_irq, req_brk, req_nm_brk, req_hw_exc, req_reset} = req;
        irq_enable = ien; brk_busy = bb; exc_busy = eb; hw_exc_in_slot = slot;
        fast_irq_mode = fm; user_ret_idx = uidx; ret_pc = pc; fast_irq_vec = fv;
        predict();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        step(6'b0, 0, 0, 0, 0, 0, '0, '0, '0);
    endtask

    initial begin
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        // R11: state held in reset
        chk("R11 reset ack", 64'(evt_ack), 64'd0);
        chk("R11 reset id", 64'(evt_id), 64'd7);
        chk("R11 reset we", 64'(ret_we), 64'd0);
        rst_n = 1'b1;

        // R1/R6/R8: everything pending, reset wins and writes nothing
        step(6'b111111, 1, 0, 0, 0, 0, 5'd3, 32'h1000, 32'h0);
        // R11: same requests right after ack are not taken
        step(6'b111111, 1, 0, 0, 0, 0, 5'd3, 32'h1000, 32'h0);
        // R5: hardware exception in delay slot goes to branch-target register
        step(6'b111110, 1, 0, 0, 1, 0, 5'd3, 32'h2004, 32'h0);
        idle();
        step(6'b000010, 0, 0, 0, 0, 0, 5'd0, 32'h2008, 32'h0);
        idle();
        // R10: non-maskable break taken while break busy; R4 vector/r16
        step(6'b001100, 1, 1, 1, 0, 0, 5'd0, 32'h3000, 32'h0);
        idle();
        // R10: maskable break blocked while busy, then taken
        step(6'b001000, 0, 1, 0, 0, 0, 5'd0, 32'h3100, 32'h0);
        step(6'b001000, 0, 0, 0, 0, 0, 5'd0, 32'h3104, 32'h0);
        idle();
        // R9: interrupt blocked by enable, exception and break in progress
        step(6'b010000, 0, 0, 0, 0, 0, 5'd0, 32'h4000, 32'h0);
        step(6'b010000, 1, 0, 1, 0, 0, 5'd0, 32'h4000, 32'h0);
        step(6'b010000, 1, 1, 0, 0, 0, 5'd0, 32'h4000, 32'h0);
        // R9: masked interrupt lets user exception through
        step(6'b110000, 0, 0, 0, 0, 0, 5'd9, 32'h4010, 32'h0);
        idle();
        // R5 and R7: interrupt by computed and by external vector
        step(6'b010000, 1, 0, 0, 0, 0, 5'd0, 32'h5000, 32'hDEAD_BEE4);
        idle();
        step(6'b010000, 1, 0, 0, 0, 1, 5'd0, 32'h5004, 32'hDEAD_BEE4);
        idle();
        // R6: user exception with chosen register; R12 data
        step(6'b100000, 0, 0, 0, 0, 1, 5'd31, 32'hCAFE_0008, 32'h0);
        idle();

        // Random mixes
        for (int k = 0; k < 3000; k++) begin
            logic [5:0] r;
            r[0] = ($urandom % 16) == 0;
            for (int b = 1; b < 6; b++) r[b] = ($urandom % 4) == 0;
            step(r, $urandom % 3 != 0, $urandom % 3 == 0, $urandom % 3 == 0,
                 1'($urandom), 1'($urandom), RW'($urandom), $urandom, $urandom);
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule